// File: doc/BRIEF.md
# Three-Wire Serial Memory Host Engine

This block lets on-chip logic reach a small external serial memory over three wires: an enable line, a serial clock and a data line. The caller places a single parallel request that gives the direction, byte or whole-array transfer, and a 7-bit location. The engine then builds the 24-bit command, shifts it out, and moves the data. Outgoing bytes come from a byte-wide ready/valid stream. Incoming bytes leave on a byte-wide output that carries a one-cycle valid strobe.

The serial clock is made from the system clock by counting. Each half period lasts `HALF_CLKS` system clocks. Once enable rises, the clock waits `SETUP_CLKS` system clocks before its first rising edge. When the final data bit has been clocked, enable drops while the serial clock is still high, and only after that does the clock return to low. Between two transfers, enable stays low for a guard interval that is set by `INACTIVE_CLKS`. If the outgoing stream has no byte ready when one is needed, the serial clock is held high until a byte arrives.

Top module: `sram3w_host`

## Requirements
- R1: Command bits 0..7 form the opcode. A write sends bits 1,0,1,1,1,0,0,1 in order (value 8'h9D). A read sends 0,1,0,0,0,1,1,0 (value 8'h62).
- R2: Command bits 8..14 carry the address with its least significant bit first, and bit 15 is 0. In a whole-array request, bits 8..14 are all 0 whatever `req_addr` holds.
- R3: Command bits 16..22 are 0. Bit 23 is 1 for a whole-array request and 0 for a single byte.
- R4: Every bit goes out least significant first. `mem_sdo` changes only while `mem_sclk` is low, so it holds steady across each high phase.
- R5: At reset and between transfers, `mem_sclk`, `mem_en`, `busy`, `done` and `rd_valid` are low and `req_ready` is high. The first rising edge comes exactly `SETUP_CLKS` system clocks after enable rises. Every later low phase lasts exactly `HALF_CLKS` system clocks.
- R6: A single-byte transfer produces 32 rising serial-clock edges. A whole-array transfer produces 24 + 8*`BURST_BYTES` rising edges.
- R7: `mem_en` falls only while `mem_sclk` is high. `done` is high for exactly one cycle, and that cycle is the first one with enable low. `busy` equals the enable state, so it rises the cycle after a request is accepted.
- R8: From the fall of enable to its next rise, enable is low for at least `INACTIVE_CLKS` system clocks.
- R9: In a write, `wr_ready` asks for the next byte at the end of the high phase of command bit 23, and again at the end of the high phase of the last bit of each byte. A byte taken on `wr_valid && wr_ready` is sent least significant first. While `wr_valid` is low, `mem_sclk` stays high.
- R10: In a read, `mem_sdi` is sampled when rising edges 25 onwards occur and is assembled least significant first. `rd_valid` pulses for one cycle after the eighth bit of each byte, with that byte on `rd_data`.
- R11: `mem_sdo_oe` is high during the 24 command bits and during write data. In a read it goes low at the falling edge after command bit 23.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken while req_ready is high |
| req_ready | output | 1 | Engine idle and guard interval over |
| req_write | input | 1 | 1 for write, 0 for read |
| req_burst | input | 1 | 1 for whole-array transfer |
| req_addr | input | 7 | Byte location for single-byte transfers |
| wr_data | input | 8 | Outgoing data byte |
| wr_valid | input | 1 | Outgoing byte available |
| wr_ready | output | 1 | Engine takes an outgoing byte this cycle |
| rd_data | output | 8 | Incoming data byte |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| busy | output | 1 | Transfer in progress (enable high) |
| done | output | 1 | One-cycle pulse when enable is released |
| mem_en | output | 1 | Memory enable |
| mem_sclk | output | 1 | Serial clock |
| mem_sdo | output | 1 | Serial data to memory |
| mem_sdo_oe | output | 1 | Drive enable for the data line |
| mem_sdi | input | 1 | Serial data from memory |

## Verification
The bound checker tests a set of rules on every cycle. Enable may fall only while the serial clock is high, and `done` must appear in that same cycle. The serial clock never rises without enable. Outgoing data holds steady through each high phase. Enable stays low for the full guard interval. Data drive, the byte request and read strobes appear only inside a transfer. A second group of properties depends on the whole transfer, so only the bench scenarios can show them. These are the exact bit pattern of the command for each mix of direction and mode, the forced-zero address in whole-array mode, the total count of edges, and the exact setup and half-period lengths. They also include the clock held high during a stalled write, and the byte values that come back from the bench's memory model.

// File: rtl/sram3w_host.sv
module sram3w_host #(
  parameter int HALF_CLKS     = 7,
  parameter int SETUP_CLKS    = 50,
  parameter int INACTIVE_CLKS = 7,
  parameter int BURST_BYTES   = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_write,
  input  logic       req_burst,
  input  logic [6:0] req_addr,
  input  logic [7:0] wr_data,
  input  logic       wr_valid,
  output logic       wr_ready,
  output logic [7:0] rd_data,
  output logic       rd_valid,
  output logic       busy,
  output logic       done,
  output logic       mem_en,
  output logic       mem_sclk,
  output logic       mem_sdo,
  output logic       mem_sdo_oe,
  input  logic       mem_sdi
);
  localparam int BURST_BITS = 24 + 8 * BURST_BYTES;
  localparam int BW         = $clog2(BURST_BITS);
  localparam int CMAX       = (HALF_CLKS > SETUP_CLKS) ?
                              ((HALF_CLKS > INACTIVE_CLKS) ? HALF_CLKS : INACTIVE_CLKS) :
                              ((SETUP_CLKS > INACTIVE_CLKS) ? SETUP_CLKS : INACTIVE_CLKS);
  localparam int CW         = $clog2(CMAX + 1);
  localparam logic [CW-1:0] HALF_LD  = CW'(HALF_CLKS - 1);
  localparam logic [CW-1:0] SETUP_LD = CW'(SETUP_CLKS - 1);
  localparam logic [CW-1:0] GAP_LD   = CW'((INACTIVE_CLKS > 3) ? INACTIVE_CLKS - 3 : 0);
  localparam logic [BW-1:0] LAST_BYTE  = BW'(31);
  localparam logic [BW-1:0] LAST_BURST = BW'(BURST_BITS - 1);
  localparam logic [BW-1:0] FIRST_DATA = BW'(24);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_HIGH, S_LOW, S_END, S_GAP} state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitc;
  logic [23:0]   sr;
  logic [7:0]    rx;
  logic          wr_q, burst_q;

  wire [23:0]   cmd_word  = {req_burst, 7'b0, 1'b0, req_burst ? 7'b0 : req_addr,
                             req_write ? 8'h9D : 8'h62};
  wire [BW-1:0] last_idx  = burst_q ? LAST_BURST : LAST_BYTE;
  wire          at_last   = bitc == last_idx;
  wire          need_byte = wr_q && (bitc[2:0] == 3'd7) && (bitc >= FIRST_DATA - BW'(1));
  wire          phase_end = cnt == '0;

  assign req_ready  = st == S_IDLE;
  assign wr_ready   = (st == S_HIGH) && phase_end && !at_last && need_byte;
  assign busy       = mem_en;
  assign rd_data    = rx;
  assign mem_sdo_oe = mem_en && (wr_q || bitc < FIRST_DATA);
  assign mem_sdo    = mem_sdo_oe & sr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      bitc     <= '0;
      sr       <= '0;
      rx       <= '0;
      wr_q     <= 1'b0;
      burst_q  <= 1'b0;
      mem_en   <= 1'b0;
      mem_sclk <= 1'b0;
      done     <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      done     <= 1'b0;
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          wr_q    <= req_write;
          burst_q <= req_burst;
          sr      <= cmd_word;
          bitc    <= '0;
          mem_en  <= 1'b1;
          cnt     <= SETUP_LD;
          st      <= S_SETUP;
        end
        S_SETUP, S_LOW: begin
          if (!phase_end) cnt <= cnt - 1'b1;
          else begin
            mem_sclk <= 1'b1;
            cnt      <= HALF_LD;
            st       <= S_HIGH;
            if (!wr_q && bitc >= FIRST_DATA) begin
              rx       <= {mem_sdi, rx[7:1]};
              rd_valid <= bitc[2:0] == 3'd7;
            end
          end
        end
        S_HIGH: begin
          if (!phase_end) cnt <= cnt - 1'b1;
          else if (at_last) begin
            mem_en <= 1'b0;
            done   <= 1'b1;
            st     <= S_END;
          end else if (!need_byte || wr_valid) begin
            sr       <= need_byte ? {16'b0, wr_data} : {1'b0, sr[23:1]};
            mem_sclk <= 1'b0;
            bitc     <= bitc + 1'b1;
            cnt      <= HALF_LD;
            st       <= S_LOW;
          end
        end
        S_END: begin
          mem_sclk <= 1'b0;
          cnt      <= GAP_LD;
          st       <= S_GAP;
        end
        default: begin
          if (!phase_end) cnt <= cnt - 1'b1;
          else st <= S_IDLE;
        end
      endcase
    end
  end
endmodule

module sram3w_host_chk #(
  parameter int INACTIVE_CLKS = 7
) (
  input logic clk,
  input logic rst_n,
  input logic mem_en,
  input logic mem_sclk,
  input logic mem_sdo,
  input logic mem_sdo_oe,
  input logic done,
  input logic wr_ready,
  input logic rd_valid
);
  int low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run <= INACTIVE_CLKS;
    else if (mem_en) low_run <= 0;
    else if (low_run < INACTIVE_CLKS) low_run <= low_run + 1;
  end

  assert_release_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_en) |-> (mem_sclk && done));
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_clock_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_sclk) |-> mem_en);
  assert_data_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_sclk && $past(mem_sclk) && $past(mem_en)) |-> $stable(mem_sdo));
  assert_guard_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_en) |-> (low_run >= INACTIVE_CLKS));
  assert_drive_in_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sdo_oe |-> mem_en);
  assert_byte_req_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (mem_en && mem_sclk));
  assert_read_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> mem_en);
endmodule

bind sram3w_host sram3w_host_chk #(.INACTIVE_CLKS(INACTIVE_CLKS)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .mem_sclk(mem_sclk), .mem_sdo(mem_sdo),
  .mem_sdo_oe(mem_sdo_oe), .done(done), .wr_ready(wr_ready), .rd_valid(rd_valid)
);

// File: tb/sram3w_host_tb.sv
module sram3w_host_tb_top;
  localparam int HALF  = 3;
  localparam int SETUP = 5;
  localparam int INACT = 6;
  localparam int BB    = 4;
  localparam int STALL = 12;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
  logic [6:0] req_addr = '0;
  logic [7:0] wr_data = '0;
  logic wr_valid = 1'b0;
  logic mem_sdi = 1'b0;
  logic req_ready, wr_ready, rd_valid, busy, done, mem_en, mem_sclk, mem_sdo, mem_sdo_oe;
  logic [7:0] rd_data;

  sram3w_host #(.HALF_CLKS(HALF), .SETUP_CLKS(SETUP), .INACTIVE_CLKS(INACT), .BURST_BYTES(BB)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_burst(req_burst), .req_addr(req_addr),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .done(done),
    .mem_en(mem_en), .mem_sclk(mem_sclk), .mem_sdo(mem_sdo),
    .mem_sdo_oe(mem_sdo_oe), .mem_sdi(mem_sdi)
  );

  int checks = 0, fails = 0;
  bit exp_bits[$];
  logic [7:0] rd_q[$];
  logic cur_wr = 1'b0;
  int cur_stall = -1, stall_left = 0, exp_rises = 0;
  int rises = 0, low_run = 0, high_run = 0, max_high = 0, setup_run = 0, en_low = 0;
  int dones = 0, busy_bad = 0, wr_idx = 0;
  bit first_seen = 0, had_txn = 0, wr_pend = 0;
  logic prev_sclk = 1'b0, prev_en = 1'b0;

  function automatic logic [7:0] wbyte(int i);
    return 8'(8'h3C + i * 37);
  endfunction
  function automatic logic [7:0] rbyte(int i);
    return 8'(8'hA6 ^ (i * 29));
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: serial line scoreboard and memory model
  always @(negedge clk) begin : mon
    logic exp_oe;
    bit b;
    int j;
    string lbl;
    if (rst_n) begin
      if (mem_en && !prev_en) begin
        if (had_txn) chk(en_low >= INACT, "R8 enable guard", en_low, INACT);
        had_txn = 1; rises = 0; setup_run = 0; first_seen = 0; max_high = 0;
      end
      if (!prev_en || !mem_en) begin end
      if (!mem_en && prev_en) begin
        chk(mem_sclk && done, "R7 release while clock high", {mem_sclk, done}, 3);
        chk(rises == exp_rises, "R6 edge count", rises, exp_rises);
      end
      if (mem_en) en_low = 0; else en_low++;
      if (done) dones++;
      if (busy != mem_en) busy_bad++;
      if (mem_en && !first_seen && !mem_sclk) setup_run++;
      if (mem_sclk && !prev_sclk) begin
        if (!first_seen) begin
          first_seen = 1;
          chk(setup_run == SETUP, "R5 setup length", setup_run, SETUP);
        end else chk(low_run == HALF, "R5 low phase", low_run, HALF);
        exp_oe = cur_wr || rises < 24;
        chk(mem_sdo_oe == exp_oe, "R11 drive enable", mem_sdo_oe, exp_oe);
        if (exp_oe) begin
          lbl = rises < 8 ? "R1 opcode bit" : rises < 16 ? "R2 address bit" :
                rises < 24 ? "R3 mode bit" : "R9 write bit R4";
          if (exp_bits.size() == 0) chk(0, "R6 extra bit", rises, -1);
          else begin
            b = exp_bits.pop_front();
            chk(mem_sdo == b, lbl, mem_sdo, b);
          end
        end
        rises++;
        high_run = 0;
      end
      if (mem_sclk) begin
        high_run++;
        if (high_run > max_high) max_high = high_run;
      end else low_run = prev_sclk ? 1 : low_run + 1;
      if (!mem_sclk && prev_sclk && mem_en && !cur_wr && rises >= 24) begin
        j = rises - 24;
        mem_sdi = rbyte(j / 8)[j % 8];
      end
      if (rd_valid) begin
        if (rd_q.size() == 0) chk(0, "R10 unexpected byte", rd_data, -1);
        else begin
          b = 0;
          chk(rd_data == rd_q[0], "R10 read byte", rd_data, rd_q[0]);
          void'(rd_q.pop_front());
        end
      end
      // write stream feeder
      if (wr_pend) wr_idx++;
      wr_data = wbyte(wr_idx);
      if (wr_idx == cur_stall && stall_left > 0) begin
        wr_valid = 1'b0;
        if (wr_ready) stall_left--;
      end else wr_valid = 1'b1;
      wr_pend = wr_ready && wr_valid;
      prev_sclk = mem_sclk;
      prev_en = mem_en;
    end
  end

  task automatic run_txn(logic w, logic bst, logic [6:0] a, int stall_byte);
    logic [23:0] cmd;
    int nb, d0;
    nb = bst ? BB : 1;
    cmd = {bst, 7'b0, 1'b0, bst ? 7'd0 : a, w ? 8'h9D : 8'h62};
    for (int i = 0; i < 24; i++) exp_bits.push_back(cmd[i]);
    for (int k = 0; k < nb; k++) begin
      if (w) for (int i = 0; i < 8; i++) exp_bits.push_back(wbyte(k)[i]);
      else rd_q.push_back(rbyte(k));
    end
    exp_rises = 24 + 8 * nb;
    cur_wr = w; cur_stall = stall_byte; stall_left = STALL; wr_idx = 0; wr_pend = 0;
    d0 = dones;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_burst = bst; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && mem_en, "R7 busy after accept", busy, 1);
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(dones == d0 + 1, "R7 single done", dones - d0, 1);
    chk(exp_bits.size() == 0, "R6 bits left", exp_bits.size(), 0);
    chk(rd_q.size() == 0, "R10 bytes left", rd_q.size(), 0);
    if (stall_byte >= 0) chk(max_high >= STALL, "R9 clock held high", max_high, STALL);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!mem_en && !mem_sclk && !busy && !done && !rd_valid && req_ready && !mem_sdo_oe,
        "R5 reset state", {mem_en, mem_sclk, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_txn(1'b1, 1'b0, 7'h55, -1);
    run_txn(1'b0, 1'b0, 7'h2A, -1);
    run_txn(1'b1, 1'b0, 7'h7F, 0);
    run_txn(1'b0, 1'b1, 7'h33, -1);
    run_txn(1'b1, 1'b1, 7'h41, 1);
    run_txn(1'b0, 1'b0, 7'h00, -1);
    repeat (20) @(negedge clk);
    chk(!mem_sclk && !mem_en && req_ready, "R5 idle after cycles", {mem_sclk, mem_en}, 0);
    chk(busy_bad == 0, "R7 busy tracks enable", busy_bad, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule